// File: doc/BRIEF.md
# DRAM Auto-Refresh Pacer

This block decides when a DDR3-style memory gets its periodic auto-refresh commands, and it drives those commands itself. An interval timer advances on an external tick. Each time it expires, the block gains one refresh credit, which stands for one refresh that is owed and not yet issued. The timer length is halved while the hot-range flag is high, so refreshes come twice as often at elevated case temperature.

While any credit is owed, the block asks the main command scheduler for the bus with a low-priority request. When the credit count reaches the postponement limit, it also raises an urgent request, which the scheduler must honour.

Once granted, the block pays off all owed credits in one burst:
- If any bank is open, it first closes every bank with a precharge-all (A10 high).
- It then issues refreshes back to back, each one spaced by the refresh cycle time.
- When the credit count reaches zero and the last refresh cycle time has run out, it hands the bus back.

Top module: `refresh_pacer`

## Requirements
- R1: With `hotRange` low, one credit is added after every `REFI_TICKS` tick pulses. `busReq` goes high one clock after the tick that brings the credit from 0 to 1.
- R2: With `hotRange` high, one credit is added after every `REFI_TICKS/2` tick pulses.
- R3: The credit count never exceeds `MAX_CREDIT`. `busUrgent` is high exactly when the count equals `MAX_CREDIT`, and `busUrgent` implies `busReq`.
- R4: `busReq` is high while credit is owed or a burst is still running. It falls once the burst completes with zero credit.
- R5: While the block is idle, no command other than NOP (`cmd` = 2'b00) leaves it unless `busGrant` is high.
- R6: If `anyBankOpen` is high when the grant is taken, the first command is precharge-all (`cmd` = 2'b01, `a10` = 1). The first refresh (`cmd` = 2'b10) follows exactly `TRP` clocks later.
- R7: If no bank is open when the grant is taken, the burst starts directly with a refresh and no precharge.
- R8: Refreshes within a burst are spaced exactly `TRFC` clocks apart. The burst issues one refresh per owed credit and then stops.
- R9: During reset `cmd` is NOP and `cke` is low. After reset `cke` is high, so it is high on every command cycle.
- R10: No two consecutive refreshes are more than `(MAX_CREDIT+1)*REFI_TICKS` tick pulses apart, provided urgent requests are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick pulse that advances the interval counter |
| hotRange | input | 1 | High selects the half-length refresh interval |
| anyBankOpen | input | 1 | High when at least one bank holds an open row |
| busGrant | input | 1 | Scheduler grants bus ownership to this block |
| busReq | output | 1 | Low-priority request for the command bus |
| busUrgent | output | 1 | Urgent request; the postponement limit has been reached |
| cmd | output | 2 | Command: 00 NOP, 01 precharge-all, 10 refresh |
| a10 | output | 1 | Address bit 10; high with precharge-all |
| cke | output | 1 | Clock enable toward the memory |

## Verification
The bench builds the block with `REFI_TICKS`=4, `TRP`=3, `TRFC`=5 and `MAX_CREDIT`=8. These short intervals let it reach the full eight-credit postponement limit and the urgent request within a few dozen tick pulses, and bring the nine-interval gap bound close to its edge. With the small timings, every precharge-to-refresh and refresh-to-refresh spacing can be compared cycle-exactly against a queue of expected commands. A hot-range pass at half interval then shows the faster rate directly.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP    = 2'b00,
    CMD_PREALL = 2'b01,
    CMD_REF    = 2'b10
  } refCmd_e;

  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic loadRp;
    logic loadRfc;
    logic busy;
  } refStrobe_s;

endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  logic       anyBankOpen,
  input  logic       creditNZ,
  input  logic       waitDone,
  output refStrobe_s strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_PRECH, ST_REFWAIT} ctrlState_e;

  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.busy = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (busGrant && creditNZ) begin
          if (anyBankOpen) begin
            strobe.issuePre = 1'b1;
            strobe.loadRp   = 1'b1;
            stateNext       = ST_PRECH;
          end else begin
            strobe.issueRef = 1'b1;
            strobe.loadRfc  = 1'b1;
            stateNext       = ST_REFWAIT;
          end
        end
      end
      ST_PRECH: begin
        if (waitDone) begin
          strobe.issueRef = 1'b1;
          strobe.loadRfc  = 1'b1;
          stateNext       = ST_REFWAIT;
        end
      end
      ST_REFWAIT: begin
        if (waitDone) begin
          if (creditNZ) begin
            strobe.issueRef = 1'b1;
            strobe.loadRfc  = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.issuePre && strobe.issueRef)); // R6

  AST_IDLE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !busGrant) |-> !(strobe.issuePre || strobe.issueRef)); // R5

endmodule

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int REFI_TICKS = 78,
  parameter int TRP        = 11,
  parameter int TRFC       = 88,
  parameter int MAX_CREDIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       hotRange,
  input  refStrobe_s strobe,
  output logic       creditNZ,
  output logic       waitDone,
  output logic       busReq,
  output logic       busUrgent,
  output logic [1:0] cmd,
  output logic       a10,
  output logic       cke
);

  localparam int TICK_W    = $clog2(REFI_TICKS + 1);
  localparam int CRED_W    = $clog2(MAX_CREDIT + 2);
  localparam int WAIT_MAX  = (TRP > TRFC) ? TRP : TRFC;
  localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
  localparam int HALF_T    = (REFI_TICKS / 2 < 1) ? 1 : REFI_TICKS / 2;
  localparam int GAP_LIMIT = (MAX_CREDIT + 1) * REFI_TICKS;
  localparam int GAP_W     = $clog2(GAP_LIMIT + 2);
  localparam int SINCE_W   = $clog2(WAIT_MAX + 2);

  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] limitM1;
  logic              expire;
  logic [CRED_W-1:0] credit;
  logic [WAIT_W-1:0] waitCnt;
  refCmd_e           cmdQ;
  logic              a10Q;
  logic              ckeQ;

  // interval timer
  assign limitM1 = hotRange ? TICK_W'(HALF_T - 1) : TICK_W'(REFI_TICKS - 1);
  assign expire  = tick && (tickCnt >= limitM1);

  always_ff @(posedge clk) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= expire ? '0 : tickCnt + 1'b1;
  end

  // postponed-refresh credit
  always_ff @(posedge clk) begin
    if (!rstN) credit <= '0;
    else begin
      case ({expire, strobe.issueRef})
        2'b10:   credit <= credit + 1'b1;
        2'b01:   credit <= credit - 1'b1;
        default: credit <= credit;
      endcase
    end
  end

  assign creditNZ  = (credit != '0);
  assign busUrgent = (credit >= CRED_W'(MAX_CREDIT));
  assign busReq    = creditNZ || strobe.busy;

  // tRP / tRFC wait counter
  always_ff @(posedge clk) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.loadRp)   waitCnt <= WAIT_W'(TRP - 1);
    else if (strobe.loadRfc)  waitCnt <= WAIT_W'(TRFC - 1);
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  // command output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= CMD_NOP;
      a10Q <= 1'b0;
      ckeQ <= 1'b0;
    end else begin
      ckeQ <= 1'b1;
      a10Q <= strobe.issuePre;
      if (strobe.issuePre)      cmdQ <= CMD_PREALL;
      else if (strobe.issueRef) cmdQ <= CMD_REF;
      else                      cmdQ <= CMD_NOP;
    end
  end

  assign cmd = cmdQ;
  assign a10 = a10Q;
  assign cke = ckeQ;

  // spacing tracker for assertions
  logic [SINCE_W-1:0] sinceCmd;
  refCmd_e            lastCmd;
  logic [GAP_W-1:0]   tickGap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceCmd <= '1;
      lastCmd  <= CMD_NOP;
    end else if (cmdQ != CMD_NOP) begin
      sinceCmd <= SINCE_W'(1);
      lastCmd  <= cmdQ;
    end else if (sinceCmd != '1) begin
      sinceCmd <= sinceCmd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         tickGap <= '0;
    else if (cmdQ == CMD_REF)          tickGap <= '0;
    else if (tick && tickGap != '1)    tickGap <= tickGap + 1'b1;
  end

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    credit <= CRED_W'(MAX_CREDIT)); // R3

  AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busUrgent |-> busReq); // R3

  AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NOP && lastCmd == CMD_PREALL) |-> sinceCmd >= SINCE_W'(TRP)); // R6

  AST_RFC_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NOP && lastCmd == CMD_REF) |-> sinceCmd >= SINCE_W'(TRFC)); // R8

  AST_PRE_A10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_PREALL) |-> a10Q); // R6

  AST_CKE_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NOP) |-> ckeQ); // R9

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickGap <= GAP_W'(GAP_LIMIT)); // R10

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pkg::*;
#(
  parameter int REFI_TICKS = 78,
  parameter int TRP        = 11,
  parameter int TRFC       = 88,
  parameter int MAX_CREDIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       hotRange,
  input  logic       anyBankOpen,
  input  logic       busGrant,
  output logic       busReq,
  output logic       busUrgent,
  output logic [1:0] cmd,
  output logic       a10,
  output logic       cke
);

  refStrobe_s strobe;
  logic       creditNZ;
  logic       waitDone;

  refresh_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busGrant    (busGrant),
    .anyBankOpen (anyBankOpen),
    .creditNZ    (creditNZ),
    .waitDone    (waitDone),
    .strobe      (strobe)
  );

  refresh_datapath #(
    .REFI_TICKS (REFI_TICKS),
    .TRP        (TRP),
    .TRFC       (TRFC),
    .MAX_CREDIT (MAX_CREDIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .hotRange  (hotRange),
    .strobe    (strobe),
    .creditNZ  (creditNZ),
    .waitDone  (waitDone),
    .busReq    (busReq),
    .busUrgent (busUrgent),
    .cmd       (cmd),
    .a10       (a10),
    .cke       (cke)
  );

endmodule

// File: tb/refresh_pacer_test.sv
`timescale 1ns/1ps
module refresh_pacer_test;

  localparam int REFI = 4;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int MAXC = 8;

  logic clk = 1'b0;
  logic rstN, tick, hotRange, anyBankOpen, busGrant;
  logic busReq, busUrgent, a10, cke;
  logic [1:0] cmd;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  int lastCmdCycle = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] code;
    int         gap;   // 0: spacing not checked
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  refresh_pacer #(
    .REFI_TICKS (REFI),
    .TRP        (TRP),
    .TRFC       (TRFC),
    .MAX_CREDIT (MAXC)
  ) uut (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .hotRange    (hotRange),
    .anyBankOpen (anyBankOpen),
    .busGrant    (busGrant),
    .busReq      (busReq),
    .busUrgent   (busUrgent),
    .cmd         (cmd),
    .a10         (a10),
    .cke         (cke)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushExp(input logic [1:0] code, input int gap, input string req);
    expItem_t it;
    it.code = code;
    it.gap  = gap;
    it.req  = req;
    expQ.push_back(it);
  endtask

  task automatic pulseTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // grant until the burst completes, then release
  task automatic runBurst();
    int waitCyc;
    @(negedge clk) busGrant = 1'b1;
    waitCyc = 0;
    while (busReq && waitCyc < 500) begin
      @(negedge clk);
      waitCyc++;
    end
    busGrant = 1'b0;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8 burst drained queue", expQ.size(), 0);
    check(busReq == 1'b0, "R4 request released", int'(busReq), 0);
  endtask

  // monitor: pops the expected queue on every command
  always @(negedge clk) begin
    cycle++;
    if (rstN && cmd != 2'b00) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected command", int'(cmd), 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(cmd == it.code, it.req, int'(cmd), int'(it.code));
        if (it.gap != 0)
          check(cycle - lastCmdCycle == it.gap, it.req,
                cycle - lastCmdCycle, it.gap);
        if (cmd == 2'b01)
          check(a10 == 1'b1, "R6 a10 with precharge-all", int'(a10), 1);
        check(cke == 1'b1, "R9 cke on command", int'(cke), 1);
      end
      lastCmdCycle = cycle;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tick = 1'b0; hotRange = 1'b0;
    anyBankOpen = 1'b0; busGrant = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd == 2'b00, "R9 reset cmd NOP", int'(cmd), 0);
    check(cke == 1'b0, "R9 reset cke low", int'(cke), 0);
    check(busReq == 1'b0, "R4 reset no request", int'(busReq), 0);
    check(busUrgent == 1'b0, "R3 reset not urgent", int'(busUrgent), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cke == 1'b1, "R9 cke high after reset", int'(cke), 1);

    // R1: normal rate, no grant yet
    pulseTicks(REFI - 1);
    check(busReq == 1'b0, "R1 no credit before interval", int'(busReq), 0);
    pulseTicks(1);
    check(busReq == 1'b1, "R1 credit after interval", int'(busReq), 1);
    check(busUrgent == 1'b0, "R3 one credit not urgent", int'(busUrgent), 0);

    // R3: postpone up to the limit with no grant
    pulseTicks(REFI * (MAXC - 2));
    check(busUrgent == 1'b0, "R3 seven credits not urgent", int'(busUrgent), 0);
    pulseTicks(REFI);
    check(busUrgent == 1'b1, "R3 urgent at limit", int'(busUrgent), 1);
    check(busReq == 1'b1, "R3 urgent implies request", int'(busReq), 1);

    // R6 + R8: open bank, eight owed refreshes
    anyBankOpen = 1'b1;
    pushExp(2'b01, 0, "R6 precharge-all first");
    pushExp(2'b10, TRP, "R6 refresh after TRP");
    for (int i = 1; i < MAXC; i++) pushExp(2'b10, TRFC, "R8 refresh after TRFC");
    runBurst();
    check(busUrgent == 1'b0, "R3 urgent cleared", int'(busUrgent), 0);

    // R2 + R7: hot range, banks closed
    anyBankOpen = 1'b0;
    hotRange    = 1'b1;
    pulseTicks(REFI / 2 - 1);
    check(busReq == 1'b0, "R2 no credit before half interval", int'(busReq), 0);
    pulseTicks(1);
    check(busReq == 1'b1, "R2 credit after half interval", int'(busReq), 1);
    pulseTicks(REFI / 2);
    pushExp(2'b10, 0, "R7 refresh without precharge");
    pushExp(2'b10, TRFC, "R8 second refresh after TRFC");
    runBurst();

    // R1 again at normal rate, then open bank single refresh
    hotRange = 1'b0;
    pulseTicks(REFI - 1);
    check(busReq == 1'b0, "R1 normal rate restored", int'(busReq), 0);
    pulseTicks(1);
    check(busReq == 1'b1, "R1 credit at normal rate", int'(busReq), 1);
    anyBankOpen = 1'b1;
    pushExp(2'b01, 0, "R6 precharge-all before single refresh");
    pushExp(2'b10, TRP, "R6 single refresh after TRP");
    runBurst();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule